// File: doc/BRIEF.md
# Sign-Magnitude to Signed Fixed-Point Coefficient Converter

This block takes one 64-bit word per accepted transfer and turns it into a 15-bit two's-complement coefficient with 12 fractional bits. The input word is in sign-magnitude form. Its top bit gives the polarity, and the remaining 63 bits hold a magnitude with 32 fractional bits. The 20 least significant fraction bits are dropped by plain truncation. A negative value is negated into two's complement. A value whose magnitude cannot fit the signed destination produces an error flag and a zero coefficient.

The block has a single register stage. A result leaves one cycle after its word is accepted. An optional grouping mode counts accepted words in sets of twelve, which is the size of a colour matrix. In this mode a marker is raised with the twelfth result, and a set-level reject is raised with it when any member of the set overflowed. A colour-pipeline loader can use this to convert a whole matrix and decide on a single flag whether to commit it.

Top module: `smag_coef_conv`

## Requirements
- R1: For a non-negative input (bit 63 = 0) that is in range, out_coef equals input bits 33:20, zero-extended to 15 bits. A value of 1.0 (bit 32 set) gives 15'h1000.
- R2: Input bits 19:0 are truncated and have no effect on out_coef or out_err. Dropping nonzero fraction bits is not an error.
- R3: For an in-range input with bit 63 = 1, out_coef is the two's complement (invert and add one) of bits 33:20, taken over 15 bits. Negative zero, and negative values whose bits 33:20 are all zero, give 0 with out_err = 0.
- R4: If any of input bits 62:34 is set, the value is out of range. In that case out_err is 1 and out_coef is 0, whatever the sign. This includes -4.0, whose magnitude only sets bit 34.
- R5: out_valid is high for exactly one cycle, one clock after each word accepted with in_valid and in_ready both high. With no accepted word, out_valid stays low.
- R6: While rst_n is low, in_ready, out_valid, out_last and out_set_err are low. After reset, in_ready is high on every cycle.
- R7: With burst_en high, accepted words are counted in sets of twelve, and idle cycles do not count. out_last is high together with the result of the twelfth word of each set, and low otherwise. A cycle with burst_en low clears the count, and out_last stays low while burst_en is low.
- R8: out_set_err is high only together with out_last. It is high when at least one word of the finished set, the last word included, was out of range, and low when none was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 64 | Sign-magnitude value, 32 fractional bits |
| burst_en | input | 1 | Enables grouping into sets of twelve |
| out_valid | output | 1 | Result valid this cycle |
| out_coef | output | 15 | Two's-complement coefficient, 12 fractional bits |
| out_err | output | 1 | Input was out of range |
| out_last | output | 1 | Result closes a set of twelve |
| out_set_err | output | 1 | Finished set held at least one out-of-range word |

## Verification
Several properties are checked on every cycle: the one-cycle link between acceptance and out_valid, the error flag against the upper magnitude bits of the accepted word, the output sign against the input sign for nonzero results, set markers that appear only with a valid result, and a set count that never leaves its range. Only the bench scenarios can show the exact coefficient values. This covers truncation of the low fraction bits, the boundary magnitudes on both sides of the range, negative zero, and how the set count behaves across idle gaps, a mid-set drop of burst_en and a set that holds an overflow at an inner position.

// File: rtl/smcc_pkg.sv
// Package: shared defaults for the coefficient converter.
// Assumes the output field keeps one sign bit above its magnitude.
package smcc_pkg;
    localparam int SMCC_IN_W      = 64;  // source word width, sign included
    localparam int SMCC_FRAC_IN   = 32;  // source fractional bits
    localparam int SMCC_OUT_W     = 15;  // destination width, sign included
    localparam int SMCC_FRAC_OUT  = 12;  // destination fractional bits
    localparam int SMCC_SET_LEN   = 12;  // words per matrix in grouping mode

    // Lowest source bit that survives truncation.
    function automatic int keep_lsb(input int frac_in, input int frac_out);
        return frac_in - frac_out;
    endfunction

    // Lowest source bit whose being set means the value cannot be represented.
    function automatic int ovf_lsb(input int frac_in, input int frac_out, input int out_w);
        return frac_in - frac_out + out_w - 1;
    endfunction
endpackage

// File: rtl/smcc_field_extract.sv
// Module: splits a sign-magnitude word into sign, kept magnitude field and
// an overflow flag. Purely combinational.
// Assumes LSB < MSB < IN_W-1. Bits below LSB are discarded by truncation.
module smcc_field_extract #(
    parameter int IN_W = 64,
    parameter int LSB  = 20,
    parameter int MSB  = 34
) (
    input  logic [IN_W-1:0]     word_i,
    output logic                sign_o,
    output logic [MSB-LSB-1:0]  field_o,
    output logic                ovf_o
);
    logic trunc_unused;

    // Sign, kept field and range test, all taken from the source bits.
    always_comb begin
        sign_o       = word_i[IN_W-1];
        field_o      = word_i[MSB-1:LSB];
        ovf_o        = |word_i[IN_W-2:MSB];
        trunc_unused = |word_i[LSB-1:0];
    end
endmodule

// File: rtl/smcc_signer.sv
// Module: turns a sign flag and an unsigned field into a two's-complement
// value of OUT_W bits. Purely combinational.
// Assumes OUT_W > FW, so the negated field never wraps.
module smcc_signer #(
    parameter int FW    = 14,
    parameter int OUT_W = 15
) (
    input  logic             sign_i,
    input  logic [FW-1:0]    field_i,
    output logic [OUT_W-1:0] coef_o
);
    localparam int PAD = OUT_W - FW;

    logic [OUT_W-1:0] ext;

    // Zero-extend, then invert and add one for negative inputs.
    always_comb begin
        ext    = {{PAD{1'b0}}, field_i};
        coef_o = sign_i ? (~ext + {{(OUT_W-1){1'b0}}, 1'b1}) : ext;
    end
endmodule

// File: rtl/smcc_burst_track.sv
// Module: counts accepted words in sets of SET_LEN while grouping is on,
// and accumulates the per-word error flag across the set.
// Outputs are combinational for the word being accepted now; the top
// registers them with the result. A cycle with grouping off clears state.
module smcc_burst_track #(
    parameter int SET_LEN = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_en,
    input  logic accept,
    input  logic elem_err,
    output logic last_o,
    output logic set_err_o
);
    localparam int CW = (SET_LEN > 1) ? $clog2(SET_LEN) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(SET_LEN - 1);

    logic [CW-1:0] count;
    logic          acc_err;

    // Flags for the word in flight: is it the set's last, did the set fail.
    always_comb begin
        last_o    = burst_en && accept && (count == LAST_IDX);
        set_err_o = last_o && (acc_err || elem_err);
    end

    // Position counter and error accumulator for the open set.
    always_ff @(posedge clk) begin
        if (!rst_n || !burst_en) begin
            count   <= '0;
            acc_err <= 1'b0;
        end else if (accept) begin
            if (count == LAST_IDX) begin
                count   <= '0;
                acc_err <= 1'b0;
            end else begin
                count   <= count + CW'(1);
                acc_err <= acc_err || elem_err;
            end
        end
    end

    assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST_IDX);

    assert_wrap_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (count == '0));
endmodule

// File: rtl/smag_coef_conv.sv
// Module: top of the sign-magnitude to two's-complement coefficient
// converter. One register stage: a result leaves one cycle after its word
// is accepted. Out-of-range words give a zero coefficient and an error.
// Assumes the consumer always takes results (no output back-pressure).
module smag_coef_conv
    import smcc_pkg::*;
#(
    parameter int IN_W     = SMCC_IN_W,
    parameter int FRAC_IN  = SMCC_FRAC_IN,
    parameter int OUT_W    = SMCC_OUT_W,
    parameter int FRAC_OUT = SMCC_FRAC_OUT,
    parameter int SET_LEN  = SMCC_SET_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_word,
    input  logic             burst_en,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_coef,
    output logic             out_err,
    output logic             out_last,
    output logic             out_set_err
);
    localparam int LSB = keep_lsb(FRAC_IN, FRAC_OUT);
    localparam int MSB = ovf_lsb(FRAC_IN, FRAC_OUT, OUT_W);
    localparam int FW  = MSB - LSB;

    logic             accept;
    logic             sign;
    logic [FW-1:0]    field;
    logic             ovf;
    logic [OUT_W-1:0] coef;
    logic             set_last;
    logic             set_err;

    assign accept = in_valid && in_ready;

    smcc_field_extract #(.IN_W(IN_W), .LSB(LSB), .MSB(MSB)) u_extract (
        .word_i  (in_word),
        .sign_o  (sign),
        .field_o (field),
        .ovf_o   (ovf)
    );

    smcc_signer #(.FW(FW), .OUT_W(OUT_W)) u_signer (
        .sign_i  (sign),
        .field_i (field),
        .coef_o  (coef)
    );

    smcc_burst_track #(.SET_LEN(SET_LEN)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .burst_en  (burst_en),
        .accept    (accept),
        .elem_err  (ovf),
        .last_o    (set_last),
        .set_err_o (set_err)
    );

    // Ready is held low during reset and high afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    // Result stage: capture the converted word, or idle the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_coef    <= '0;
            out_err     <= 1'b0;
            out_last    <= 1'b0;
            out_set_err <= 1'b0;
        end else begin
            out_valid   <= accept;
            out_last    <= set_last;
            out_set_err <= set_err;
            if (accept) begin
                out_coef <= ovf ? '0 : coef;
                out_err  <= ovf;
            end
        end
    end

    assert_one_cycle_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_err_matches_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_err == $past(|in_word[IN_W-2:MSB])));

    assert_sign_follows_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && (out_coef != '0)) |-> (out_coef[OUT_W-1] == $past(in_word[IN_W-1])));

    assert_last_with_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_no_last_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_en |=> !out_last);

    assert_set_err_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_set_err |-> out_last);
endmodule

// File: tb/smag_coef_conv_test.sv
// Bench: table-driven conversion checks, then directed reset and grouping tests.
module smag_coef_conv_test;
    localparam time CYC = 4ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [63:0] in_word;
    logic        burst_en;
    logic        out_valid;
    logic [14:0] out_coef;
    logic        out_err;
    logic        out_last;
    logic        out_set_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CYC/2) clk = ~clk;

    smag_coef_conv uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .burst_en(burst_en), .out_valid(out_valid),
        .out_coef(out_coef), .out_err(out_err), .out_last(out_last),
        .out_set_err(out_set_err)
    );

    typedef struct packed {
        logic [63:0] word;
        logic [14:0] coef;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{64'h0000_0000_0000_0000, 15'h0000, 1'b0, 4'd1},  // R1 zero
        '{64'h0000_0001_0000_0000, 15'h1000, 1'b0, 4'd1},  // R1 +1.0
        '{64'h0000_0003_FFF0_0000, 15'h3FFF, 1'b0, 4'd1},  // R1 largest positive
        '{64'h0000_0000_0010_0000, 15'h0001, 1'b0, 4'd1},  // R1 one step
        '{64'h0000_0000_8000_1234, 15'h0800, 1'b0, 4'd2},  // R2 low bits dropped
        '{64'h0000_0000_000F_FFFF, 15'h0000, 1'b0, 4'd2},  // R2 only truncated bits
        '{64'h8000_0001_0000_0000, 15'h7000, 1'b0, 4'd3},  // R3 -1.0
        '{64'h8000_0003_FFF0_0000, 15'h4001, 1'b0, 4'd3},  // R3 most negative legal
        '{64'h8000_0000_800F_FFFF, 15'h7800, 1'b0, 4'd3},  // R3 -0.5 with junk
        '{64'h8000_0000_0010_0000, 15'h7FFF, 1'b0, 4'd3},  // R3 minus one step
        '{64'h8000_0000_0000_0000, 15'h0000, 1'b0, 4'd3},  // R3 negative zero
        '{64'h0000_0004_0000_0000, 15'h0000, 1'b1, 4'd4},  // R4 +4.0
        '{64'h8000_0004_0000_0000, 15'h0000, 1'b1, 4'd4},  // R4 -4.0
        '{64'h4000_0000_0000_0000, 15'h0000, 1'b1, 4'd4},  // R4 bit 62 only
        '{64'h8000_0100_0010_0000, 15'h0000, 1'b1, 4'd4}   // R4 bit 40 with field
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Offer one word at a falling edge and move to the next falling edge.
    task automatic send(input logic [63:0] w);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_word = '0; burst_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 in_ready in reset", 64'(in_ready), 64'd0);
        chk("R6 out_valid in reset", 64'(out_valid), 64'd0);
        chk("R6 out_last in reset", 64'(out_last), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 in_ready after reset", 64'(in_ready), 64'd1);
        chk("R5 no output without accept", 64'(out_valid), 64'd0);

        // Table walk, words offered back to back.
        for (int i = 0; i < NV; i++) begin
            send(VEC[i].word);
            chk($sformatf("R5 valid vec %0d", i), 64'(out_valid), 64'd1);
            chk($sformatf("R%0d coef vec %0d", VEC[i].req, i), 64'(out_coef), 64'(VEC[i].coef));
            chk($sformatf("R%0d err vec %0d", VEC[i].req, i), 64'(out_err), 64'(VEC[i].err));
            chk("R7 no last with grouping off", 64'(out_last), 64'd0);
        end
        in_word = 64'h4000_0000_0000_0000;
        idle();
        chk("R5 idle gives no result", 64'(out_valid), 64'd0);
        idle();
        chk("R5 idle stays quiet", 64'(out_valid), 64'd0);

        // R7/R8: set with an overflow at position 5 and an idle gap.
        burst_en = 1'b1;
        idle();
        for (int k = 0; k < 12; k++) begin
            send((k == 5) ? 64'h0000_0008_0000_0000 : 64'(k) << 20);
            chk($sformatf("R7 last pos %0d", k), 64'(out_last), 64'(k == 11));
            chk($sformatf("R8 set_err pos %0d", k), 64'(out_set_err), 64'(k == 11));
            if (k == 6) begin
                idle();
                chk("R7 gap no last", 64'(out_last), 64'd0);
            end
        end

        // R8: clean set.
        for (int k = 0; k < 12; k++) begin
            send(64'h8000_0001_0000_0000);
            chk($sformatf("R7 clean last pos %0d", k), 64'(out_last), 64'(k == 11));
            chk($sformatf("R8 clean set_err pos %0d", k), 64'(out_set_err), 64'd0);
        end

        // R8: overflow only on the final word.
        for (int k = 0; k < 12; k++) begin
            send((k == 11) ? 64'h0000_0010_0000_0000 : 64'h0);
            chk($sformatf("R8 tail set_err pos %0d", k), 64'(out_set_err), 64'(k == 11));
        end

        // R7: dropping burst_en mid-set restarts the count.
        for (int k = 0; k < 4; k++) begin
            send(64'h0000_0004_0000_0000);
            chk("R7 partial no last", 64'(out_last), 64'd0);
        end
        burst_en = 1'b0;
        idle();
        burst_en = 1'b1;
        for (int k = 0; k < 12; k++) begin
            send(64'h0000_0001_0000_0000);
            chk($sformatf("R7 restart last pos %0d", k), 64'(out_last), 64'(k == 11));
            chk($sformatf("R8 restart set_err pos %0d", k), 64'(out_set_err), 64'd0);
        end

        // R7: grouping off, many words, never a marker.
        burst_en = 1'b0;
        for (int k = 0; k < 14; k++) begin
            send(64'h0000_0004_0000_0000);
            chk("R7 off no last", 64'(out_last), 64'd0);
            chk("R8 off no set_err", 64'(out_set_err), 64'd0);
        end

        // R6: reset mid-stream clears strobes.
        in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        chk("R6 ready low in reset", 64'(in_ready), 64'd0);
        chk("R6 valid low in reset", 64'(out_valid), 64'd0);
        in_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CYC * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule